// File: doc/BRIEF.md
# Lane-Control Register Bank with Bit-Masked Writes

This block is a small bank of 32-bit control registers for a camera receiver PHY. Every write word has two halves. The lower 16 bits carry data. The upper 16 bits carry a per-bit write enable for that data. Software can therefore change one field, or a single bit, in one bus write, with no read-modify-write. Bits whose enable is clear keep their stored value. The enable half itself is never stored.

The bank holds the PHY's lane-control fields:
- lane enables
- forced receive mode
- forced stop mode
- turnaround disable and turnaround request
- two clock-invert selects

It also holds a test-port group: data-in, enable, clock and clear. All of these fields leave the block as parallel outputs. A read-only status word returns the PHY's 8-bit test data-out.

Reads are registered: the data for the word index presented on the address appears on `bus_rdata` one clock later. Word indices:

| Index | Register |
|---|---|
| 0 | lane control |
| 1 | turnaround / clock invert |
| 2 | test port |
| 3 | status (read-only) |

All other indices are unmapped.

Top module: `lanectl_regbank`

## Requirements
- R1: A write to a mapped register loads data bit n (n in 0..15) only when bit n+16 of the same write word is 1. Every other stored bit keeps its previous value.
- R2: To write a field, software puts the value at the field's shift and an all-ones mask of the field's width at that shift plus 16. Fields of the same register that are not covered by the mask are unchanged.
- R3: Index 0 holds four 4-bit fields, read back at the same positions:
  - `lane_en` at bits 3:0
  - `force_rx` at bits 7:4
  - `force_stop` at bits 11:8
  - `turn_dis` at bits 15:12
- R4: Index 1 holds:
  - `turn_req` at bits 3:0
  - `clk_inv[0]` at bit 10
  - `clk_inv[1]` at bit 11

  Its other bits cannot be set and always read as 0.
- R5: Index 2 holds:
  - `test_din` at bits 7:0
  - `test_en` at bit 8
  - `test_clk` at bit 9
  - `test_clr` at bit 10

  Bits 15:11 always read as 0.
- R6: Index 3 is read-only. It returns `test_dout` in bits 7:0 and zero above. Writes to it change no register and no output.
- R7: `bus_rdata` is registered. It shows the word at the index presented on `bus_addr` one clock earlier. Bits 31:16 of `bus_rdata` are always 0.
- R8: After a synchronous active-low reset, every stored bit, every field output and `bus_rdata` are 0.
- R9: A write to an unmapped index (4 and above) changes no register and no output.
- R10: A write whose upper half is all zero leaves the addressed register unchanged, whatever its lower half holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | ADDR_W | Word index for writes and reads |
| bus_wdata | input | 32 | Write word: enable mask in 31:16, data in 15:0 |
| bus_rdata | output | 32 | Registered read data |
| test_dout | input | 8 | Test data-out returned by the PHY |
| lane_en | output | 4 | Per-lane enable |
| force_rx | output | 4 | Per-lane forced receive mode |
| force_stop | output | 4 | Per-lane forced stop mode |
| turn_dis | output | 4 | Per-lane turnaround disable |
| turn_req | output | 4 | Per-lane turnaround request |
| clk_inv | output | 2 | Clock-invert selects |
| test_din | output | 8 | Test-port data-in |
| test_en | output | 1 | Test-port enable |
| test_clk | output | 1 | Test-port clock |
| test_clr | output | 1 | Test-port clear |

## Verification
The assertions watch several rules on every cycle:
- A write bit whose enable is clear never changes its stored bit.
- A write with an all-zero mask, or no write at all, leaves a register stable.
- Writes to unmapped indices leave every output stable.
- The status read returns the previous cycle's `test_dout`.
- The upper read half is always zero.

Only the bench scenarios can show the rest:
- Each field sits at its stated position.
- A field write leaves its neighbours alone.
- Unimplemented bits read zero.
- Reset clears everything.

// File: rtl/lcr_pkg.sv
// Package: shared word indices and implemented-bit masks of the lane-control bank.
// Assumes a word-indexed bus; the half width is fixed at 16 by the masked-write scheme.
package lcr_pkg;
    localparam int HALF_W   = 16;
    localparam int WORD_W   = 2 * HALF_W;
    localparam int IDX_LANE = 0;
    localparam int IDX_TURN = 1;
    localparam int IDX_TEST = 2;
    localparam int IDX_STAT = 3;
    localparam int N_STORED = 3;
    localparam logic [HALF_W-1:0] IMPL_LANE = 16'hFFFF;
    localparam logic [HALF_W-1:0] IMPL_TURN = 16'h0C0F;
    localparam logic [HALF_W-1:0] IMPL_TEST = 16'h07FF;
    localparam int STAT_W   = 8;
endpackage

// File: rtl/lcr_masked_reg.sv
// Module: one 16-bit register with per-bit write enables taken from the upper
// half of the write word. Bits clear in IMPL are never set and read as zero.
// Assumes the caller asserts sel_we only for a write addressed to this register.
module lcr_masked_reg
    import lcr_pkg::*;
#(
    parameter logic [HALF_W-1:0] IMPL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we,
    input  logic [WORD_W-1:0] wdata,
    output logic [HALF_W-1:0] q
);
    for (genvar i = 0; i < HALF_W; i++) begin : g_bit
        // Purpose: hold one bit, loading it only when its enable bit is set.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (sel_we && wdata[HALF_W+i])
                q[i] <= wdata[i] & IMPL[i];
        end

        // R1: a bit whose enable is clear keeps its value across the write.
        assert_bit_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_we && !wdata[HALF_W+i]) |=> $stable(q[i]));
    end

    // R10: an all-zero mask leaves the whole register unchanged.
    assert_zero_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_we && wdata[WORD_W-1:HALF_W] == '0) |=> $stable(q));

    // R9: with no write selected the register holds.
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_we |=> $stable(q));
endmodule

// File: rtl/lcr_readmux.sv
// Module: combinational read selection over the stored registers and the
// status word. Assumes unmapped indices return zero.
module lcr_readmux
    import lcr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] r_lane,
    input  logic [HALF_W-1:0] r_turn,
    input  logic [HALF_W-1:0] r_test,
    input  logic [STAT_W-1:0] stat,
    output logic [WORD_W-1:0] rdata
);
    // Purpose: pick the addressed word, zero-extended to the bus width.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(IDX_LANE))
            rdata[HALF_W-1:0] = r_lane;
        else if (addr == ADDR_W'(IDX_TURN))
            rdata[HALF_W-1:0] = r_turn;
        else if (addr == ADDR_W'(IDX_TEST))
            rdata[HALF_W-1:0] = r_test;
        else if (addr == ADDR_W'(IDX_STAT))
            rdata[STAT_W-1:0] = stat;
    end
endmodule

// File: rtl/lanectl_regbank.sv
// Module: top of the lane-control register bank. Decodes writes to three
// masked registers, fans their fields out and registers the read data.
// Assumes one bus access per cycle and a synchronous active-low reset.
module lanectl_regbank
    import lcr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [7:0]        test_dout,
    output logic [3:0]        lane_en,
    output logic [3:0]        force_rx,
    output logic [3:0]        force_stop,
    output logic [3:0]        turn_dis,
    output logic [3:0]        turn_req,
    output logic [1:0]        clk_inv,
    output logic [7:0]        test_din,
    output logic              test_en,
    output logic              test_clk,
    output logic              test_clr
);
    localparam logic [HALF_W-1:0] IMPL_TAB [N_STORED] = '{IMPL_LANE, IMPL_TURN, IMPL_TEST};

    logic [N_STORED-1:0] we;
    logic [HALF_W-1:0]   regs [N_STORED];
    logic [WORD_W-1:0]   rd_next;

    for (genvar k = 0; k < N_STORED; k++) begin : g_reg
        // Purpose: decode a write to stored register k.
        assign we[k] = bus_wr && (bus_addr == ADDR_W'(k));

        lcr_masked_reg #(.IMPL(IMPL_TAB[k])) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .sel_we(we[k]),
            .wdata (bus_wdata),
            .q     (regs[k])
        );
    end

    // Purpose: fan the stored fields out to the PHY controls.
    assign lane_en    = regs[IDX_LANE][3:0];
    assign force_rx   = regs[IDX_LANE][7:4];
    assign force_stop = regs[IDX_LANE][11:8];
    assign turn_dis   = regs[IDX_LANE][15:12];
    assign turn_req   = regs[IDX_TURN][3:0];
    assign clk_inv    = regs[IDX_TURN][11:10];
    assign test_din   = regs[IDX_TEST][7:0];
    assign test_en    = regs[IDX_TEST][8];
    assign test_clk   = regs[IDX_TEST][9];
    assign test_clr   = regs[IDX_TEST][10];

    lcr_readmux #(.ADDR_W(ADDR_W)) u_rmux (
        .addr  (bus_addr),
        .r_lane(regs[IDX_LANE]),
        .r_turn(regs[IDX_TURN]),
        .r_test(regs[IDX_TEST]),
        .stat  (test_dout),
        .rdata (rd_next)
    );

    // Purpose: register the read data one cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else
            bus_rdata <= rd_next;
    end

    // R6: a status read returns the previous cycle's test data-out.
    assert_status_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(IDX_STAT)) |=> (bus_rdata == {24'h0, $past(test_dout)}));

    // R7: the upper read half never carries data.
    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:16] == 16'h0);

    // R9: a write to an unmapped or read-only index leaves every field output stable.
    assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr >= ADDR_W'(IDX_STAT))
        |=> $stable({lane_en, force_rx, force_stop, turn_dis, turn_req, clk_inv,
                     test_din, test_en, test_clk, test_clr}));
endmodule

// File: tb/sim_lanectl_regbank.sv
module sim_lanectl_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  test_dout = '0;
    logic [3:0]  lane_en, force_rx, force_stop, turn_dis, turn_req;
    logic [1:0]  clk_inv;
    logic [7:0]  test_din;
    logic        test_en, test_clk, test_clr;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] m_reg [3];
    logic [15:0] impl  [3];

    always #10 clk = ~clk;

    lanectl_regbank #(.ADDR_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .test_dout(test_dout),
        .lane_en(lane_en), .force_rx(force_rx), .force_stop(force_stop),
        .turn_dis(turn_dis), .turn_req(turn_req), .clk_inv(clk_inv),
        .test_din(test_din), .test_en(test_en), .test_clk(test_clk),
        .test_clr(test_clr)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] upd(input logic [15:0] old, input logic [31:0] w,
                                        input logic [15:0] im);
        return ((old & ~w[31:16]) | (w[15:0] & w[31:16])) & im;
    endfunction

    task automatic wr(input int idx, input logic [31:0] w);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(idx); bus_wdata = w;
        @(negedge clk);
        bus_wr = 1'b0;
        if (idx < 3) m_reg[idx] = upd(m_reg[idx], w, impl[idx]);
    endtask

    task automatic rd(input int idx, output logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 4'(idx);
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic check_all(input string req);
        logic [31:0] v;
        chk(req, {lane_en, force_rx, force_stop, turn_dis},
            {m_reg[0][3:0], m_reg[0][7:4], m_reg[0][11:8], m_reg[0][15:12]});
        chk(req, {turn_req, clk_inv}, {m_reg[1][3:0], m_reg[1][11:10]});
        chk(req, {test_din, test_en, test_clk, test_clr},
            {m_reg[2][7:0], m_reg[2][8], m_reg[2][9], m_reg[2][10]});
        for (int k = 0; k < 3; k++) begin
            rd(k, v);
            chk(req, v, {16'h0, m_reg[k]});
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(0, v);
        chk("R8 rdata", v, 32'h0);
        check_all("R8");
    endtask

    task automatic t_lane_fields;
        logic [31:0] v;
        wr(0, 32'h000F_0005);
        chk("R2 lane_en", lane_en, 4'h5);
        wr(0, 32'h00F0_00A0);
        chk("R2 neighbour kept", lane_en, 4'h5);
        chk("R3 force_rx", force_rx, 4'hA);
        wr(0, 32'hFF00_C300);
        chk("R3 force_stop", force_stop, 4'h3);
        chk("R3 turn_dis", turn_dis, 4'hC);
        rd(0, v);
        chk("R3 R7 readback", v, 32'h0000_C3A5);
    endtask

    task automatic t_bitmask;
        wr(0, 32'h8102_0000);
        wr(0, 32'h0040_FFFF);
        check_all("R1");
        chk("R1 force_rx", force_rx, 4'hE);
    endtask

    task automatic t_zero_mask;
        for (int k = 0; k < 3; k++) wr(k, 32'h0000_FFFF);
        check_all("R10");
    endtask

    task automatic t_turn;
        logic [31:0] v;
        wr(1, 32'hFFFF_FFFF);
        rd(1, v);
        chk("R4 readback", v, 32'h0000_0C0F);
        chk("R4 clk_inv", clk_inv, 2'b11);
        wr(1, 32'h0400_0000);
        chk("R4 clk_inv bit10", clk_inv, 2'b10);
        chk("R4 turn_req", turn_req, 4'hF);
    endtask

    task automatic t_test;
        logic [31:0] v;
        wr(2, 32'h00FF_005A);
        chk("R5 test_din", test_din, 8'h5A);
        wr(2, 32'hFF00_FF00);
        rd(2, v);
        chk("R5 readback", v, 32'h0000_075A);
        chk("R5 test bits", {test_clr, test_clk, test_en}, 3'b111);
        wr(2, 32'h0200_0000);
        chk("R5 test_clk clear", {test_clr, test_clk, test_en}, 3'b101);
    endtask

    task automatic t_status;
        logic [31:0] v;
        test_dout = 8'h3C;
        rd(3, v);
        chk("R6 status", v, 32'h0000_003C);
        wr(3, 32'hFFFF_FFFF);
        test_dout = 8'hC5;
        rd(3, v);
        chk("R6 status after write", v, 32'h0000_00C5);
        check_all("R6");
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(4, 32'hFFFF_FFFF);
        wr(7, 32'hFFFF_0000);
        wr(15, 32'hFFFF_FFFF);
        rd(5, v);
        chk("R9 unmapped read", v, 32'h0);
        check_all("R9");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        impl[0] = 16'hFFFF;
        impl[1] = 16'h0C0F;
        impl[2] = 16'h07FF;
        for (int k = 0; k < 3; k++) m_reg[k] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_lane_fields;
        t_bitmask;
        t_zero_mask;
        t_turn;
        t_test;
        t_status;
        t_unmapped;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule